// File: doc/BRIEF.md
# Integer ALU with Operation Decoder

This block is the arithmetic-logic unit of a simple processor datapath, with a small operation decoder in front of it. It is purely combinational. A 2-bit operation class comes from the main control. A 6-bit function field comes from the instruction word. The decoder turns these two inputs into a 3-bit operation select. The ALU then applies that operation to two operands of `WIDTH` bits.

The supported operations are bitwise AND, bitwise OR, add, subtract and signed set-on-less-than. Alongside the result, the ALU reports a zero flag and a signed overflow flag. The zero flag lets the control take a branch on equality after a subtract. The class field decides whether the function field is consulted at all.

Address arithmetic and branch comparisons force add or subtract through the class. Register-to-register instructions pass class 10 so that the function field picks the operation.

There is no state machine and no clock. Names follow the same conventions as the rest of the code base.

Top module: `alu_unit`

## Requirements
- R1: Operation class 00 and class 11 both select add (result = A + B), whatever the function field holds.
- R2: Operation class 01 selects subtract (result = A - B), whatever the function field holds.
- R3: With class 10, the function field selects the operation: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 set-on-less-than.
- R4: With class 10, any function code not listed in R3 selects add.
- R5: AND and OR produce the bitwise AND and the bitwise OR of A and B.
- R6: Add and subtract wrap modulo 2^WIDTH.
- R7: Set-on-less-than compares A and B as signed two's-complement values. Bit 0 of the result is 1 when A < B, and all other result bits are 0.
- R8: `zero_o` is 1 exactly when every bit of `result_o` is 0, for every operation.
- R9: For add, `overflow_o` is 1 exactly when A and B have the same sign bit and the result sign bit differs from that of A.
- R10: For subtract, `overflow_o` is 1 exactly when A and B have different sign bits and the result sign bit differs from that of A.
- R11: `overflow_o` is 0 for AND, OR and set-on-less-than, including the case where the internal subtraction of set-on-less-than overflows.
- R12: The outputs settle in the same cycle as the inputs change. No clock or stored state is involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_class_i | input | 2 | Operation class from the control unit |
| funct_i | input | 6 | Function field from the instruction word |
| result_o | output | WIDTH | Operation result |
| zero_o | output | 1 | Result is all zeros |
| overflow_o | output | 1 | Signed overflow of add or subtract |

## Verification
The bench builds the block with the default `WIDTH` of 32. At this width, the sign-boundary operands 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF exercise the exact overflow rules of add and subtract. They also reach the case where set-on-less-than must still give the right answer while its internal subtraction overflows.

Every class is driven with both listed and unlisted function codes. This shows that the function field matters only under class 10. Pseudo-random operand pairs across all operations then cover the general arithmetic and flag behaviour.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

    // Operation select. Bit 2 puts the adder in subtract mode;
    // bits 1:0 pick the result source.
    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } op_sel_e;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FUNCT = 2'b10,
        CLS_ALT   = 2'b11
    } op_class_e;

    localparam int FUNCT_W = 6;

    localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;

endpackage

// File: rtl/alu_op_decoder.sv
`timescale 1ns/1ps
module alu_op_decoder
    import alu_pkg::*;
(
    input  logic [1:0]         op_class_i,
    input  logic [FUNCT_W-1:0] funct_i,
    output op_sel_e            op_sel_o
);

    op_sel_e funct_sel;

    // Function field decode; unknown codes fall back to add (R4)
    always_comb begin
        case (funct_i)
            FN_ADD:  funct_sel = OP_ADD;
            FN_SUB:  funct_sel = OP_SUB;
            FN_AND:  funct_sel = OP_AND;
            FN_OR:   funct_sel = OP_OR;
            FN_SLT:  funct_sel = OP_SLT;
            default: funct_sel = OP_ADD;
        endcase
    end

    // Class decode (R1, R2, R3)
    always_comb begin
        op_sel_o = OP_ADD;
        unique case (op_class_e'(op_class_i))
            CLS_ADD:   op_sel_o = OP_ADD;
            CLS_SUB:   op_sel_o = OP_SUB;
            CLS_FUNCT: op_sel_o = funct_sel;
            CLS_ALT:   op_sel_o = OP_ADD;
        endcase
    end

endmodule

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             ovf_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;

    // One shared adder: subtract = add inverted B plus one
    always_comb begin
        b_eff = b_i ^ {WIDTH{sub_i}};
        sum_o = a_i + b_eff + {{(WIDTH-1){1'b0}}, sub_i};
        ovf_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
    end

endmodule

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
module alu_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             or_mode_i,
    output logic [WIDTH-1:0] res_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign res_o[i] = or_mode_i ? (a_i[i] | b_i[i]) : (a_i[i] & b_i[i]);
    end

endmodule

// File: rtl/alu_unit.sv
`timescale 1ns/1ps
module alu_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    input  logic [1:0]         op_class_i,
    input  logic [FUNCT_W-1:0] funct_i,
    output logic [WIDTH-1:0]   result_o,
    output logic               zero_o,
    output logic               overflow_o
);

    op_sel_e          op_sel;
    logic [WIDTH-1:0] arith_sum;
    logic             arith_ovf;
    logic [WIDTH-1:0] logic_res;
    logic             arith_op;

    alu_op_decoder u_dec (
        .op_class_i (op_class_i),
        .funct_i    (funct_i),
        .op_sel_o   (op_sel)
    );

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i   (a_i),
        .b_i   (b_i),
        .sub_i (op_sel[2]),
        .sum_o (arith_sum),
        .ovf_o (arith_ovf)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i       (a_i),
        .b_i       (b_i),
        .or_mode_i (op_sel[0]),
        .res_o     (logic_res)
    );

    // Result select on op_sel[1:0]; signed less-than = sign xor overflow (R7)
    always_comb begin
        unique case (op_sel[1:0])
            2'b00: result_o = logic_res;
            2'b01: result_o = logic_res;
            2'b10: result_o = arith_sum;
            2'b11: result_o = {{(WIDTH-1){1'b0}}, arith_sum[WIDTH-1] ^ arith_ovf};
        endcase
    end

    // Flags (R8, R9, R10, R11)
    always_comb begin
        arith_op   = (op_sel == OP_ADD) || (op_sel == OP_SUB);
        overflow_o = arith_op && arith_ovf;
        zero_o     = ~|result_o;
    end

endmodule

// File: rtl/alu_unit_checker.sv
`timescale 1ns/1ps
module alu_unit_checker
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0]   a_i,
    input logic [WIDTH-1:0]   b_i,
    input logic [1:0]         op_class_i,
    input op_sel_e            op_sel,
    input logic [WIDTH-1:0]   result_o,
    input logic               zero_o,
    input logic               overflow_o
);

    always_comb begin
        // R1
        if (op_class_i == 2'b00 || op_class_i == 2'b11)
            a_r1_class_add: assert (op_sel == OP_ADD);
        // R2
        if (op_class_i == 2'b01)
            a_r2_class_sub: assert (op_sel == OP_SUB);
        // R6
        if (op_sel == OP_ADD)
            a_r6_add_inverse: assert (result_o - b_i == a_i);
        if (op_sel == OP_SUB)
            a_r6_sub_inverse: assert (result_o + b_i == a_i);
        // R7
        if (op_sel == OP_SLT)
            a_r7_slt_shape: assert (result_o[WIDTH-1:1] == '0);
        // R8
        if (result_o != '0)
            a_r8_zero_clear: assert (!zero_o);
        // R9
        if (op_sel == OP_ADD && a_i[WIDTH-1] != b_i[WIDTH-1])
            a_r9_mixed_add: assert (!overflow_o);
        // R10
        if (op_sel == OP_SUB && a_i[WIDTH-1] == b_i[WIDTH-1])
            a_r10_like_sub: assert (!overflow_o);
        // R11
        if (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_SLT)
            a_r11_no_overflow: assert (!overflow_o);
    end

endmodule

bind alu_unit alu_unit_checker #(.WIDTH(WIDTH)) u_alu_unit_checker (
    .a_i        (a_i),
    .b_i        (b_i),
    .op_class_i (op_class_i),
    .op_sel     (op_sel),
    .result_o   (result_o),
    .zero_o     (zero_o),
    .overflow_o (overflow_o)
);

// File: tb/alu_unit_bench.sv
`timescale 1ns/1ps
module alu_unit_bench;

    localparam int W = 32;

    typedef struct {
        logic [W-1:0] res;
        logic         zero;
        logic         ovf;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [1:0]   cls = 2'b00;
    logic [5:0]   fn = '0;
    logic [W-1:0] res;
    logic         zero;
    logic         ovf;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    alu_unit #(.WIDTH(W)) u_alu_unit (
        .a_i        (a),
        .b_i        (b),
        .op_class_i (cls),
        .funct_i    (fn),
        .result_o   (res),
        .zero_o     (zero),
        .overflow_o (ovf)
    );

    // Reference built from the requirements
    function automatic exp_t model(logic [W-1:0] x, logic [W-1:0] y,
                                   logic [1:0] c, logic [5:0] f, string tag);
        exp_t e;
        int   op;  // 0 and, 1 or, 2 add, 3 sub, 4 slt
        op = 2;
        if (c == 2'b01) op = 3;
        else if (c == 2'b10) begin
            case (f)
                6'b100010: op = 3;
                6'b100100: op = 0;
                6'b100101: op = 1;
                6'b101010: op = 4;
                default:   op = 2;
            endcase
        end
        e.ovf = 1'b0;
        case (op)
            0: e.res = x & y;
            1: e.res = x | y;
            2: begin
                e.res = x + y;
                e.ovf = (x[W-1] == y[W-1]) && (e.res[W-1] != x[W-1]);
            end
            3: begin
                e.res = x - y;
                e.ovf = (x[W-1] != y[W-1]) && (e.res[W-1] != x[W-1]);
            end
            default: e.res = ($signed(x) < $signed(y)) ? 1 : 0;
        endcase
        e.zero = (e.res == '0);
        e.tag  = tag;
        return e;
    endfunction

    task automatic drive(logic [W-1:0] x, logic [W-1:0] y,
                         logic [1:0] c, logic [5:0] f, string tag);
        @(posedge clk);
        a = x; b = y; cls = c; fn = f;
        exp_q.push_back(model(x, y, c, f, tag));
    endtask

    // Monitor: compares away from the driving edge (R12: same-cycle result)
    always @(negedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (res !== e.res || zero !== e.zero || ovf !== e.ovf) begin
                errors++;
                $display("FAIL %s: got res=%h zero=%b ovf=%b, expected res=%h zero=%b ovf=%b",
                         e.tag, res, zero, ovf, e.res, e.zero, e.ovf);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles, expected under 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset/idle state: all-zero inputs give add of zeros (R8, R1)
        drive('0, '0, 2'b00, 6'b000000, "R1_R8_idle");
        // R1: class 00/11 add regardless of funct
        drive(32'd5, 32'd7, 2'b00, 6'b100100, "R1");
        drive(32'd5, 32'd7, 2'b11, 6'b101010, "R1");
        // R2: class 01 subtract regardless of funct
        drive(32'd9, 32'd4, 2'b01, 6'b100101, "R2");
        drive(32'd4, 32'd9, 2'b01, 6'b100000, "R2");
        // R3: function decode
        drive(32'h0000_00F0, 32'h0000_0F0F, 2'b10, 6'b100000, "R3");
        drive(32'h0000_00F0, 32'h0000_0F0F, 2'b10, 6'b100010, "R3");
        drive(32'hF0F0_1234, 32'hFF00_FF00, 2'b10, 6'b100100, "R3_R5");
        drive(32'hF0F0_1234, 32'h0F00_0001, 2'b10, 6'b100101, "R3_R5");
        drive(32'd3, 32'd8, 2'b10, 6'b101010, "R3_R7");
        // R4: unknown function codes add
        drive(32'd100, 32'd23, 2'b10, 6'b000000, "R4");
        drive(32'd100, 32'd23, 2'b10, 6'b111111, "R4");
        drive(32'd100, 32'd23, 2'b10, 6'b100011, "R4");
        // R5: AND to zero sets zero flag
        drive(32'hAAAA_AAAA, 32'h5555_5555, 2'b10, 6'b100100, "R5_R8");
        drive(32'hAAAA_AAAA, 32'h5555_5555, 2'b10, 6'b100101, "R5");
        // R6: wrap
        drive(32'hFFFF_FFFF, 32'd1, 2'b00, 6'b0, "R6_R8");
        drive(32'd0, 32'd1, 2'b01, 6'b0, "R6");
        // R7: signed compare
        drive(32'hFFFF_FFFF, 32'd1, 2'b10, 6'b101010, "R7");
        drive(32'd1, 32'hFFFF_FFFF, 2'b10, 6'b101010, "R7");
        drive(32'd6, 32'd6, 2'b10, 6'b101010, "R7_R8");
        // R7/R11: compare across an overflowing internal subtraction
        drive(32'h8000_0000, 32'h7FFF_FFFF, 2'b10, 6'b101010, "R7_R11");
        drive(32'h7FFF_FFFF, 32'h8000_0000, 2'b10, 6'b101010, "R7_R11");
        // R8: subtract equal values
        drive(32'h1234_5678, 32'h1234_5678, 2'b01, 6'b0, "R8");
        // R9: add overflow boundaries
        drive(32'h7FFF_FFFF, 32'd1, 2'b00, 6'b0, "R9");
        drive(32'h8000_0000, 32'h8000_0000, 2'b00, 6'b0, "R9_R8");
        drive(32'h7FFF_FFFF, 32'h8000_0000, 2'b00, 6'b0, "R9");
        drive(32'h7FFF_FFFE, 32'd1, 2'b10, 6'b100000, "R9");
        // R10: subtract overflow boundaries
        drive(32'h8000_0000, 32'd1, 2'b01, 6'b0, "R10");
        drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'b01, 6'b0, "R10");
        drive(32'h8000_0000, 32'hFFFF_FFFF, 2'b10, 6'b100010, "R10");
        drive(32'hFFFF_FFFF, 32'h8000_0000, 2'b01, 6'b0, "R10");
        // R11: logic ops with operands that would overflow an add
        drive(32'h8000_0000, 32'h8000_0000, 2'b10, 6'b100100, "R11");
        drive(32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'b10, 6'b100101, "R11");
        // Pseudo-random sweep over all classes and codes (R6, R12)
        for (int i = 0; i < 400; i++) begin
            logic [5:0] f;
            case (i % 7)
                0: f = 6'b100000;
                1: f = 6'b100010;
                2: f = 6'b100100;
                3: f = 6'b100101;
                4: f = 6'b101010;
                default: f = 6'($urandom);
            endcase
            drive(W'($urandom), W'($urandom), 2'($urandom), f, "R6_R12_random");
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R12: got %0d pending items, expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule